// File: doc/BRIEF.md
# Priority Pin-Assignment Crossbar

This block places a fixed, ordered set of digital peripheral signals onto a bank of port pins without any per-pin function select. Software enables whole functions and may mark pins as skipped. Hardware then walks the signal list in priority order and gives each signal of an enabled function the lowest-numbered pin that is neither skipped nor already taken. Every pin that no signal takes, including each skipped pin, is driven from the general-purpose data and direction registers.

The function set is fixed in the package. Function 0 is a serial port with a transmit output (signal 0) followed by a receive input (signal 1). Function 1 is a pair of outputs (signals 2 and 3). Function 2 is a single pulse output (signal 4). Function 3 is a single capture input (signal 5). The placement order is signal 0 up to signal 5.

The placement map is held in registers. It follows a change of the enables or the skip mask one clock later. Pin drive and input routing are also registered, and they use the map that is currently in force. For each signal the block reports whether the signal was placed and which pin it got. An overflow flag reports an enabled signal that found no free pin.

Top module: `priority_xbar`

## Requirements
- R1: Signals of enabled functions are placed in ascending signal index order, each on the lowest-numbered pin that is not skipped and not taken by an earlier signal.
- R2: A pin whose `skip_en` bit is 1 is never claimed, and the placement passes over it.
- R3: `overflow` is 1 exactly when some signal of an enabled function found no free pin. Such a signal reports `sig_placed`=0 and pin field 0, and it drives no pin.
- R4: A signal of a disabled function reports `sig_placed`=0 and pin field 0, uses no pin and does not move any other signal.
- R5: A function with two signals takes its signals in fixed order: the transmit output comes before the receive input, and the first output of the pair comes before the second.
- R6: `sig_placed`, `sig_pin` (pin of signal s in bits [s*PIN_W +: PIN_W]), `pin_claimed` and `overflow` reflect `fn_en` and `skip_en` one clock after they change.
- R7: A pin claimed by an output signal drives that signal's `per_out` and `per_oe` one clock later. A pin claimed by an input signal has `pin_oe`=0 and `pin_out`=0.
- R8: An unclaimed pin, skipped or not, drives `gpio_out` and `gpio_dir` (1 = drive) one clock later.
- R9: `per_in[s]` equals the assigned pin's `pin_in` one clock later. When signal s is unplaced, it reads the idle level instead: 1 for the receive input (signal 1) and 0 for all other signals.
- R10: While `rst` is 1, `sig_placed`, `sig_pin`, `pin_claimed`, `overflow`, `pin_out` and `pin_oe` are 0, and `per_in` holds the idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_en | input | NUM_FN (4) | Function enable, one bit per function |
| skip_en | input | NUM_PINS | Pin skip mask |
| per_out | input | NUM_SIG (6) | Peripheral output value per signal |
| per_oe | input | NUM_SIG (6) | Peripheral output enable per signal |
| gpio_out | input | NUM_PINS | General-purpose output data |
| gpio_dir | input | NUM_PINS | General-purpose direction, 1 = drive |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_out | output | NUM_PINS | Registered pin output value |
| pin_oe | output | NUM_PINS | Registered pin output enable |
| pin_claimed | output | NUM_PINS | Pin is held by a peripheral signal |
| per_in | output | NUM_SIG (6) | Registered input value per signal |
| sig_pin | output | NUM_SIG*PIN_W | Assigned pin index per signal |
| sig_placed | output | NUM_SIG (6) | Signal holds a pin |
| overflow | output | 1 | An enabled signal found no free pin |

## Verification
Some properties are checked by assertions on every cycle. A skipped pin is never claimed. The number of claimed pins equals the number of placed signals. A disabled function never reports a placed signal. Overflow implies that no free pin is left. Every unclaimed pin follows the general-purpose registers. Every unplaced signal reads its idle level. Other behaviour shows only in the bench scenarios: the exact pin each signal receives under a given enable and skip pattern, the order inside a function, the one-clock latency of the map, and the routing of pin levels to the inputs.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_FN  = 4;
  localparam int NUM_SIG = 6;
  localparam int SIG_W   = $clog2(NUM_SIG);

  // signal 1 (serial receive) and signal 5 (capture) are inputs
  localparam logic [NUM_SIG-1:0] SIG_IS_IN = 6'b100010;
  // idle level read by an unplaced signal
  localparam logic [NUM_SIG-1:0] SIG_IDLE  = 6'b000010;

  // owning function of each signal, in placement order
  function automatic int unsigned sig_fn(input int unsigned s);
    case (s)
      0, 1:    return 0;
      2, 3:    return 1;
      4:       return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/xbar_placer.sv
module xbar_placer
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_FN-1:0]         fn_en,
  input  logic [NUM_PINS-1:0]       skip_en,
  output logic [NUM_SIG-1:0]        placed,
  output logic [NUM_SIG*PIN_W-1:0]  pins,
  output logic [NUM_PINS*SIG_W-1:0] owner,
  output logic [NUM_PINS-1:0]       claimed,
  output logic                      ovf
);
  logic [NUM_PINS-1:0] used;
  logic                found;

  always_comb begin
    used    = skip_en;
    placed  = '0;
    pins    = '0;
    owner   = '0;
    claimed = '0;
    ovf     = 1'b0;
    found   = 1'b0;
    for (int s = 0; s < NUM_SIG; s++) begin
      if (fn_en[sig_fn(s)]) begin
        found = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!found && !used[p]) begin
            found                    = 1'b1;
            used[p]                  = 1'b1;
            claimed[p]               = 1'b1;
            placed[s]                = 1'b1;
            pins[s*PIN_W +: PIN_W]   = PIN_W'(p);
            owner[p*SIG_W +: SIG_W]  = SIG_W'(s);
          end
        end
        if (!found) ovf = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_pin_drive.sv
module xbar_pin_drive
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       claimed,
  input  logic [NUM_PINS*SIG_W-1:0] owner,
  input  logic [NUM_SIG-1:0]        per_out,
  input  logic [NUM_SIG-1:0]        per_oe,
  input  logic [NUM_PINS-1:0]       gpio_out,
  input  logic [NUM_PINS-1:0]       gpio_dir,
  output logic [NUM_PINS-1:0]       pin_out,
  output logic [NUM_PINS-1:0]       pin_oe
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SIG_W-1:0] own;
    assign own = owner[p*SIG_W +: SIG_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[p] <= 1'b0;
        pin_oe[p]  <= 1'b0;
      end else if (claimed[p]) begin
        if (SIG_IS_IN[own]) begin
          pin_out[p] <= 1'b0;
          pin_oe[p]  <= 1'b0;
        end else begin
          pin_out[p] <= per_out[own];
          pin_oe[p]  <= per_oe[own];
        end
      end else begin
        pin_out[p] <= gpio_out[p];
        pin_oe[p]  <= gpio_dir[p];
      end
    end
  end
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SIG-1:0]       placed,
  input  logic [NUM_SIG*PIN_W-1:0] pins,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_SIG-1:0]       per_in
);
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    logic [PIN_W-1:0] src;
    assign src = pins[s*PIN_W +: PIN_W];

    always_ff @(posedge clk) begin
      if (rst)            per_in[s] <= SIG_IDLE[s];
      else if (placed[s]) per_in[s] <= pin_in[src];
      else                per_in[s] <= SIG_IDLE[s];
    end
  end
endmodule

// File: rtl/priority_xbar.sv
module priority_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_FN-1:0]        fn_en,
  input  logic [NUM_PINS-1:0]      skip_en,
  input  logic [NUM_SIG-1:0]       per_out,
  input  logic [NUM_SIG-1:0]       per_oe,
  input  logic [NUM_PINS-1:0]      gpio_out,
  input  logic [NUM_PINS-1:0]      gpio_dir,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_PINS-1:0]      pin_oe,
  output logic [NUM_PINS-1:0]      pin_claimed,
  output logic [NUM_SIG-1:0]       per_in,
  output logic [NUM_SIG*PIN_W-1:0] sig_pin,
  output logic [NUM_SIG-1:0]       sig_placed,
  output logic                     overflow
);
  logic [NUM_SIG-1:0]        placed_d,  placed_q;
  logic [NUM_SIG*PIN_W-1:0]  pins_d,    pins_q;
  logic [NUM_PINS*SIG_W-1:0] owner_d,   owner_q;
  logic [NUM_PINS-1:0]       claimed_d, claimed_q;
  logic                      ovf_d,     ovf_q;

  xbar_placer #(.NUM_PINS(NUM_PINS)) u_placer (
    .fn_en   (fn_en),
    .skip_en (skip_en),
    .placed  (placed_d),
    .pins    (pins_d),
    .owner   (owner_d),
    .claimed (claimed_d),
    .ovf     (ovf_d)
  );

  // map register: a new map is in force one clock after a config change
  always_ff @(posedge clk) begin
    if (rst) begin
      placed_q  <= '0;
      pins_q    <= '0;
      owner_q   <= '0;
      claimed_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      placed_q  <= placed_d;
      pins_q    <= pins_d;
      owner_q   <= owner_d;
      claimed_q <= claimed_d;
      ovf_q     <= ovf_d;
    end
  end

  xbar_pin_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .claimed  (claimed_q),
    .owner    (owner_q),
    .per_out  (per_out),
    .per_oe   (per_oe),
    .gpio_out (gpio_out),
    .gpio_dir (gpio_dir),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  xbar_in_route #(.NUM_PINS(NUM_PINS)) u_route (
    .clk    (clk),
    .rst    (rst),
    .placed (placed_q),
    .pins   (pins_q),
    .pin_in (pin_in),
    .per_in (per_in)
  );

  assign pin_claimed = claimed_q;
  assign sig_pin     = pins_q;
  assign sig_placed  = placed_q;
  assign overflow    = ovf_q;
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FN-1:0]    fn_en,
  input logic [NUM_PINS-1:0]  skip_en,
  input logic [NUM_PINS-1:0]  gpio_out,
  input logic [NUM_PINS-1:0]  gpio_dir,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [NUM_PINS-1:0]  pin_oe,
  input logic [NUM_PINS-1:0]  pin_claimed,
  input logic [NUM_SIG-1:0]   per_in,
  input logic [NUM_SIG-1:0]   sig_placed,
  input logic                 overflow
);
  // R2: a skipped pin is never claimed
  p_skip_free_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_claimed & $past(skip_en)) == '0);

  // R3: overflow only when every pin is either skipped or taken
  p_overflow_full_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> &(pin_claimed | $past(skip_en)));

  // R4: one claimed pin per placed signal
  p_claim_count_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(pin_claimed) == $countones(sig_placed));

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    // R4: disabled function places nothing
    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(fn_en[sig_fn(s)]) |-> !sig_placed[s]);
    // R9: unplaced signal reads its idle level
    p_idle_in_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(sig_placed[s])) |-> per_in[s] == SIG_IDLE[s]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R8: unclaimed pin follows the general-purpose registers
    p_gpio_fallback_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pin_claimed[p])) |->
        (pin_oe[p] == $past(gpio_dir[p]) && pin_out[p] == $past(gpio_out[p])));
  end
endmodule

bind priority_xbar xbar_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fn_en       (fn_en),
  .skip_en     (skip_en),
  .gpio_out    (gpio_out),
  .gpio_dir    (gpio_dir),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .pin_claimed (pin_claimed),
  .per_in      (per_in),
  .sig_placed  (sig_placed),
  .overflow    (overflow)
);

// File: tb/tb_priority_xbar.sv
module tb_priority_xbar;
  import xbar_pkg::*;
  localparam int NP = 8;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_FN-1:0]     fn_en    = '0;
  logic [NP-1:0]         skip_en  = '0;
  logic [NUM_SIG-1:0]    per_out  = '0;
  logic [NUM_SIG-1:0]    per_oe   = '0;
  logic [NP-1:0]         gpio_out = '0;
  logic [NP-1:0]         gpio_dir = '0;
  logic [NP-1:0]         pin_in   = '0;
  logic [NP-1:0]         pin_out, pin_oe, pin_claimed;
  logic [NUM_SIG-1:0]    per_in, sig_placed;
  logic [NUM_SIG*PW-1:0] sig_pin;
  logic                  overflow;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  priority_xbar #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst(rst), .fn_en(fn_en), .skip_en(skip_en),
    .per_out(per_out), .per_oe(per_oe), .gpio_out(gpio_out),
    .gpio_dir(gpio_dir), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_claimed(pin_claimed), .per_in(per_in),
    .sig_pin(sig_pin), .sig_placed(sig_placed), .overflow(overflow)
  );

  typedef struct packed {
    logic [3:0]  en;
    logic [7:0]  skip;
    logic [5:0]  placed;
    logic [17:0] pins;   // {s5,s4,s3,s2,s1,s0}, 3 bits each
    logic        ovf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 8'h00, 6'b111111, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 1'b0},
    '{4'b0001, 8'h00, 6'b000011, {3'd0,3'd0,3'd0,3'd0,3'd1,3'd0}, 1'b0},
    '{4'b1010, 8'h00, 6'b101100, {3'd2,3'd0,3'd1,3'd0,3'd0,3'd0}, 1'b0},
    '{4'b1111, 8'h05, 6'b111111, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd1}, 1'b0},
    '{4'b1111, 8'h07, 6'b011111, {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3}, 1'b1},
    '{4'b0100, 8'hFE, 6'b010000, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 1'b0},
    '{4'b0100, 8'hFF, 6'b000000, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 1'b1},
    '{4'b0000, 8'h00, 6'b000000, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 1'b0},
    '{4'b1001, 8'h12, 6'b100011, {3'd3,3'd0,3'd0,3'd0,3'd2,3'd0}, 1'b0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // advance to just after the next rising edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [NP-1:0] claim_of(input vec_t v);
    logic [NP-1:0] c = '0;
    for (int s = 0; s < NUM_SIG; s++)
      if (v.placed[s]) c[v.pins[s*3 +: 3]] = 1'b1;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R10: reset state while inputs are busy
    fn_en = 4'hF; gpio_dir = 8'hFF; gpio_out = 8'hFF; pin_in = 8'hFF;
    tick(3);
    chk("R10 sig_placed in reset", 32'(sig_placed), 0);
    chk("R10 pin_claimed in reset", 32'(pin_claimed), 0);
    chk("R10 pin_oe in reset", 32'(pin_oe), 0);
    chk("R10 pin_out in reset", 32'(pin_out), 0);
    chk("R10 overflow in reset", 32'(overflow), 0);
    chk("R10 per_in idle in reset", 32'(per_in), 32'h02);
    fn_en = '0; gpio_dir = '0; gpio_out = '0; pin_in = '0;
    rst = 1'b0;
    tick(2);

    // vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      fn_en   = VECS[i].en;
      skip_en = VECS[i].skip;
      tick(1);
      chk($sformatf("R1/R4/R5 vector %0d sig_placed", i), 32'(sig_placed), 32'(VECS[i].placed));
      chk($sformatf("R1/R2/R5 vector %0d sig_pin", i), 32'(sig_pin), 32'(VECS[i].pins));
      chk($sformatf("R3 vector %0d overflow", i), 32'(overflow), 32'(VECS[i].ovf));
      chk($sformatf("R2/R6 vector %0d pin_claimed", i), 32'(pin_claimed), 32'(claim_of(VECS[i])));
    end

    // R6: the map changes one clock after the enables, not before
    fn_en = 4'b0000; skip_en = 8'h00; tick(2);
    fn_en = 4'b0100;
    #1;
    chk("R6 map unchanged before edge", 32'(sig_placed), 0);
    tick(1);
    chk("R6 map after one clock", 32'(sig_placed), 32'h10);
    chk("R6 claim after one clock", 32'(pin_claimed), 32'h01);

    // R7 R8: serial port on pins 0 and 1, the rest general-purpose
    fn_en = 4'b0001; skip_en = 8'h00;
    per_out = 6'b000001; per_oe = 6'b000001;
    gpio_out = 8'b1010_1100; gpio_dir = 8'b1111_0000;
    tick(3);
    chk("R7/R8 pin_out mix", 32'(pin_out), 32'b1010_1101);
    chk("R7/R8 pin_oe mix", 32'(pin_oe), 32'b1111_0001);
    per_out = 6'b000000;
    tick(1);
    chk("R7 peripheral data one clock later", 32'(pin_out), 32'b1010_1100);

    // R8: skipped pin 0 stays general-purpose, transmit moves to pin 1
    skip_en = 8'h01; per_out = 6'b000001; per_oe = 6'b000001;
    gpio_out = 8'h01; gpio_dir = 8'h01;
    tick(3);
    chk("R8 skipped pin out", 32'(pin_out), 32'h03);
    chk("R8 skipped pin oe", 32'(pin_oe), 32'h03);

    // R9: receive input on pin 2
    pin_in = 8'b1111_1011; tick(1);
    chk("R9 receive reads pin 2 low", 32'(per_in[1]), 0);
    pin_in = 8'b0000_0100; tick(1);
    chk("R9 receive reads pin 2 high", 32'(per_in[1]), 1);
    fn_en = 4'b0000; pin_in = 8'h00; tick(3);
    chk("R9 unplaced receive idles high", 32'(per_in[1]), 1);
    pin_in = 8'hFF; tick(1);
    chk("R9 unplaced capture idles low", 32'(per_in[5]), 0);
    fn_en = 4'b1000; pin_in = 8'h00; tick(3);
    pin_in = 8'h02; tick(1);
    chk("R9 capture reads pin 1", 32'(per_in[5]), 1);

    // R3: unplaced outputs drive nothing
    fn_en = 4'b0011; skip_en = 8'b1111_1100;
    per_out = 6'b001101; per_oe = 6'b001101;
    gpio_out = 8'h00; gpio_dir = 8'h00;
    tick(3);
    chk("R3 overflow with pair unplaced", 32'(overflow), 1);
    chk("R3 unplaced placed flags", 32'(sig_placed), 32'h03);
    chk("R3 unplaced outputs pin_oe", 32'(pin_oe), 32'h01);
    chk("R3 unplaced outputs pin_out", 32'(pin_out), 32'h01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule